// File: doc/BRIEF.md
# FSK Channel Loopback Test Sequencer

This block runs a loopback test over a set of radio transmit/receive paths. It visits the paths one after another, from the highest numbered down to path 1. For each path it puts a frequency-shift carrier on the path and checks the tone detector and the demodulated data that come back. The tone generator and the demodulator are outside the block. The block only drives the channel select, the carrier enable and the frequency-select line, and it samples the two returned lines at fixed points in time.

All timing comes from a slow reference clock, nominally 640 Hz, which is asynchronous to the system clock. The reference is passed through a synchronizer, and each falling edge becomes a one-cycle tick. For each path the block waits until the path reports no activity and a tick arrives. It then enables the carrier at the high tone and makes a first check after a set number of ticks. Next it moves to the low tone and makes a second check after a further delay. If a check fails, or if a path never goes quiet before its watchdog runs out, the run stops at once with a fault code and the number of the failing path. If every path passes, the block reports the good code.

Top module: `fsk_loop_seq`

## Requirements
- R1: After reset, ch_sel is 0, carrier_en, freq_hi and done are 0, and result is 2'b00 (none).
- R2: A run started by start visits ch_sel = N_CH, N_CH-1, ... down to 1, each value one less than the one before.
- R3: When a path is selected, freq_hi goes to 1 (high tone) in the same cycle, before carrier_en rises.
- R4: carrier_en rises only in the cycle after a synchronized falling edge of ref_clk_in, and only while ch_busy bit (ch_sel-1) is 0. With SYNC_STAGES=2, a falling edge of the reference is acted on at the third rising clock edge after it.
- R5: On the SETTLE_PERIODS-th reference falling edge after the carrier turns on, the block requires tone_det_n=0 and rx_data=0. If they hold, freq_hi drops to 0.
- R6: On the (SETTLE_PERIODS+SHIFT_DELAY_PERIODS)-th falling edge after freq_hi drops, the block requires tone_det_n=0 and rx_data=1.
- R7: When both checks pass, carrier_en and freq_hi go to 0 and the next lower path is selected. After path 1 passes, done=1 and result=2'b01 (good), with ch_sel left at 1.
- R8: A failed check turns off carrier_en and freq_hi in the following cycle. It also sets done=1 and result=2'b10 (fault), and ch_sel keeps the number of the failing path. No lower path is tested.
- R9: If the selected path is still busy at WDOG_PERIODS reference falling edges in a row, the block reports a fault (R8 outputs) on that path.
- R10: start is ignored while a run is in progress. In the idle or done state it begins a new run and clears done and result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a test run (idle or done only) |
| ref_clk_in | input | 1 | Asynchronous reference clock, nominally 640 Hz |
| ch_busy | input | N_CH | Per-path activity flag, bit i for path i+1 |
| tone_det_n | input | 1 | Active-low 2880 Hz tone detector output |
| rx_data | input | 1 | Demodulated receive data |
| ch_sel | output | CH_W | Selected path number (0 before any run) |
| carrier_en | output | 1 | Carrier on |
| freq_hi | output | 1 | 1 = 3200 Hz tone, 0 = 2560 Hz tone |
| done | output | 1 | Run finished, result valid |
| result | output | 2 | 00 none, 01 good, 10 fault |

## Verification
The sequencer is first run with an ideal loopback model, where the detector stays low and the receive data follows the tone. This confirms the descending visit order and the alignment of each step to reference edges. A run where path 2 stays busy for part of its wait shows the wait for an idle path, without the watchdog firing. Two faults are injected: a stuck detector on the first path, which fails the first check, and receive data stuck at 0 on path 2, which fails only the second check. Together they show which check caught the fault and that the lower paths are skipped. A path that is busy for the whole run triggers the watchdog. A start pulse in the middle of a run, followed by a restart from the done state, covers how start is handled.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
   typedef enum logic [1:0] {
      RES_NONE  = 2'd0,
      RES_GOOD  = 2'd1,
      RES_FAULT = 2'd2
   } res_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_SETTLE,
      ST_SHIFT,
      ST_DONE
   } st_e;
endpackage

// File: rtl/fsk_ref_edge.sv
module fsk_ref_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_in,
   output logic fall
);
   localparam int PW = STAGES + 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fsk_ref_edge: STAGES must be at least 2");
      end
   endgenerate

   // pipe[0..STAGES-1] synchronize, pipe[STAGES] holds the previous level
   logic [PW-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[PW-2:0], ref_in};
   end

   assign fall = pipe[STAGES] & ~pipe[STAGES-1];
endmodule

// File: rtl/fsk_tick_cnt.sv
module fsk_tick_cnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         tick,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/fsk_seq_ctrl.sv
module fsk_seq_ctrl
   import fsk_pkg::*;
#(
   parameter int N_CH   = 3,
   parameter int CH_W   = 2,
   parameter int CNT_W  = 4,
   parameter int SETTLE = 2,
   parameter int SHIFT  = 1,
   parameter int WDOG   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             fall,
   input  logic [N_CH-1:0]  ch_busy,
   input  logic             det_n,
   input  logic             rx,
   input  logic [CNT_W-1:0] per_cnt,
   input  logic [CNT_W-1:0] wd_cnt,
   output logic             per_clr,
   output logic             wd_clr,
   output logic [CH_W-1:0]  ch_sel,
   output logic             carrier_en,
   output logic             freq_hi,
   output logic             done,
   output logic [1:0]       result
);
   localparam logic [CNT_W-1:0] HIT1 = CNT_W'(SETTLE - 1);
   localparam logic [CNT_W-1:0] HIT2 = CNT_W'(SETTLE + SHIFT - 1);
   localparam logic [CNT_W-1:0] WHIT = CNT_W'(WDOG - 1);

   st_e             state;
   logic [CH_W-1:0] sel_idx;
   logic            sel_busy, hit1, hit2, whit;
   logic            fail_now, pass_ch, launch;

   always_comb begin
      sel_idx  = (ch_sel == '0) ? '0 : ch_sel - 1'b1;
      sel_busy = ch_busy[sel_idx];
      hit1     = fall && (per_cnt == HIT1);
      hit2     = fall && (per_cnt == HIT2);
      whit     = fall && sel_busy && (wd_cnt == WHIT);
      launch   = (state == ST_WAIT) && fall && !sel_busy;
      fail_now = ((state == ST_WAIT)   && whit)
              || ((state == ST_SETTLE) && hit1 && (det_n || rx))
              || ((state == ST_SHIFT)  && hit2 && (det_n || !rx));
      pass_ch  = (state == ST_SHIFT) && hit2 && !det_n && rx;
      per_clr  = !((state == ST_SETTLE) || (state == ST_SHIFT)) || ((state == ST_SETTLE) && hit1);
      wd_clr   = (state != ST_WAIT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         ch_sel     <= '0;
         carrier_en <= 1'b0;
         freq_hi    <= 1'b0;
         done       <= 1'b0;
         result     <= RES_NONE;
      end else if (fail_now) begin
         state      <= ST_DONE;
         carrier_en <= 1'b0;
         freq_hi    <= 1'b0;
         done       <= 1'b1;
         result     <= RES_FAULT;
      end else begin
         unique case (state)
            ST_IDLE, ST_DONE: if (start) begin
               state   <= ST_WAIT;
               ch_sel  <= CH_W'(N_CH);
               freq_hi <= 1'b1;
               done    <= 1'b0;
               result  <= RES_NONE;
            end
            ST_WAIT: if (launch) begin
               carrier_en <= 1'b1;
               state      <= ST_SETTLE;
            end
            ST_SETTLE: if (hit1) begin
               freq_hi <= 1'b0;
               state   <= ST_SHIFT;
            end
            ST_SHIFT: if (pass_ch) begin
               carrier_en <= 1'b0;
               if (ch_sel == CH_W'(1)) begin
                  state  <= ST_DONE;
                  done   <= 1'b1;
                  result <= RES_GOOD;
               end else begin
                  ch_sel  <= ch_sel - 1'b1;
                  freq_hi <= 1'b1;
                  state   <= ST_WAIT;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/fsk_loop_seq.sv
module fsk_loop_seq #(
   parameter int N_CH                = 3,
   parameter int SYNC_STAGES         = 2,
   parameter int SETTLE_PERIODS      = 2,
   parameter int SHIFT_DELAY_PERIODS = 1,
   parameter int WDOG_PERIODS        = 640,
   localparam int CH_W               = $clog2(N_CH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            ref_clk_in,
   input  logic [N_CH-1:0] ch_busy,
   input  logic            tone_det_n,
   input  logic            rx_data,
   output logic [CH_W-1:0] ch_sel,
   output logic            carrier_en,
   output logic            freq_hi,
   output logic            done,
   output logic [1:0]      result
);
   localparam int SPAN    = SETTLE_PERIODS + SHIFT_DELAY_PERIODS;
   localparam int CNT_MAX = (SPAN > WDOG_PERIODS) ? SPAN : WDOG_PERIODS;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   generate
      if (N_CH < 1 || SETTLE_PERIODS < 1 || SHIFT_DELAY_PERIODS < 0 || WDOG_PERIODS < 1) begin : g_bad_cfg
         $error("fsk_loop_seq: illegal parameter set");
      end
   endgenerate

   logic             ref_fall;
   logic             per_clr, wd_clr;
   logic [CNT_W-1:0] per_cnt, wd_cnt;

   fsk_ref_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_clk_in), .fall(ref_fall)
   );

   fsk_tick_cnt #(.W(CNT_W)) u_per_cnt (
      .clk(clk), .rst_n(rst_n), .clr(per_clr), .tick(ref_fall), .cnt(per_cnt)
   );

   fsk_tick_cnt #(.W(CNT_W)) u_wd_cnt (
      .clk(clk), .rst_n(rst_n), .clr(wd_clr), .tick(ref_fall), .cnt(wd_cnt)
   );

   fsk_seq_ctrl #(
      .N_CH(N_CH), .CH_W(CH_W), .CNT_W(CNT_W),
      .SETTLE(SETTLE_PERIODS), .SHIFT(SHIFT_DELAY_PERIODS), .WDOG(WDOG_PERIODS)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .fall(ref_fall),
      .ch_busy(ch_busy), .det_n(tone_det_n), .rx(rx_data),
      .per_cnt(per_cnt), .wd_cnt(wd_cnt), .per_clr(per_clr), .wd_clr(wd_clr),
      .ch_sel(ch_sel), .carrier_en(carrier_en), .freq_hi(freq_hi),
      .done(done), .result(result)
   );
endmodule

// File: rtl/fsk_loop_seq_chk.sv
module fsk_loop_seq_chk #(
   parameter int N_CH = 3,
   parameter int CH_W = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic [N_CH-1:0] ch_busy,
   input logic [CH_W-1:0] ch_sel,
   input logic            carrier_en,
   input logic            freq_hi,
   input logic            done,
   input logic [1:0]      result,
   input logic            ref_fall
);
   logic [CH_W-1:0] idx;
   logic            sel_busy;

   always_comb begin
      idx      = (ch_sel == '0) ? '0 : ch_sel - 1'b1;
      sel_busy = (ch_sel == '0) ? 1'b1 : ch_busy[idx];
   end

   // R4: carrier starts only after a synchronized fall on an idle path
   a_r4_carrier_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(carrier_en) |-> ($past(ref_fall) && !$past(sel_busy)));

   // R3: carrier always starts at the high tone
   a_r3_high_tone_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(carrier_en) |-> freq_hi);

   // R2: path numbers step down by one during a run
   a_r2_descending: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(ch_sel) && !$past(done) && ($past(ch_sel) != '0))
      |-> (ch_sel == $past(ch_sel) - 1'b1));

   // R6: the low tone is only selected with the carrier running
   a_r6_low_tone_live: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(freq_hi) && !done) |-> carrier_en);

   // R8: a fault leaves the path quiet
   a_r8_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (done && result == 2'b10) |-> (!carrier_en && !freq_hi));

   // R7: a good result only after path 1
   a_r7_good_last: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(done) && result == 2'b01) |-> (ch_sel == CH_W'(1)));

   // R1: result is only non-empty while done
   a_r1_result_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      (result != 2'b00) |-> done);
endmodule

bind fsk_loop_seq fsk_loop_seq_chk #(.N_CH(N_CH), .CH_W(CH_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ch_busy(ch_busy), .ch_sel(ch_sel),
   .carrier_en(carrier_en), .freq_hi(freq_hi), .done(done),
   .result(result), .ref_fall(ref_fall)
);

// File: tb/fsk_loop_seq_tb.sv
`timescale 1ns/1ps
module fsk_loop_seq_tb_top;
   localparam int N_CH     = 3;
   localparam int SETTLE   = 2;
   localparam int SHIFT    = 1;
   localparam int WDOG     = 4;
   localparam int REF_HALF = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       ref_clk_in = 1'b0;
   logic [2:0] ch_busy = '0;
   logic       tone_det_n = 1'b0;
   logic       rx_data = 1'b0;
   logic [1:0] ch_sel;
   logic       carrier_en, freq_hi, done;
   logic [1:0] result;

   int checks = 0;
   int fails = 0;
   bit finished = 0;

   int det_bad_ch = 0;
   int rx_bad_ch  = 0;
   int ref_div    = 0;

   fsk_loop_seq #(
      .N_CH(N_CH), .SYNC_STAGES(2), .SETTLE_PERIODS(SETTLE),
      .SHIFT_DELAY_PERIODS(SHIFT), .WDOG_PERIODS(WDOG)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .ref_clk_in(ref_clk_in),
      .ch_busy(ch_busy), .tone_det_n(tone_det_n), .rx_data(rx_data),
      .ch_sel(ch_sel), .carrier_en(carrier_en), .freq_hi(freq_hi),
      .done(done), .result(result)
   );

   always #2 clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference model
   bit ref_q[$] = '{0, 0, 0};
   int m_phase = 0;  // 0 idle, 1 waiting, 2 first tone, 3 second tone, 4 finished
   int m_ch = 0, m_car = 0, m_fhi = 0, m_done = 0, m_res = 0, m_pc = 0, m_wc = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         ref_q = '{0, 0, 0};
         m_phase = 0; m_ch = 0; m_car = 0; m_fhi = 0; m_done = 0; m_res = 0;
         m_pc = 0; m_wc = 0;
      end else begin
         bit edge_seen;
         bit busy_now;
         edge_seen = ref_q[2] && !ref_q[1];
         busy_now  = (m_ch > 0) ? ch_busy[m_ch-1] : 1'b1;
         ref_q.push_front(ref_clk_in);
         void'(ref_q.pop_back());
         case (m_phase)
            0, 4: if (start) begin
               m_phase = 1; m_ch = N_CH; m_fhi = 1; m_done = 0; m_res = 0; m_wc = 0;
            end
            1: if (edge_seen) begin
               if (!busy_now) begin m_car = 1; m_phase = 2; m_pc = 0; end
               else if (m_wc == WDOG - 1) begin
                  m_car = 0; m_fhi = 0; m_done = 1; m_res = 2; m_phase = 4;
               end else m_wc++;
            end
            2: if (edge_seen) begin
               if (m_pc == SETTLE - 1) begin
                  if (!tone_det_n && !rx_data) begin m_fhi = 0; m_phase = 3; m_pc = 0; end
                  else begin m_car = 0; m_fhi = 0; m_done = 1; m_res = 2; m_phase = 4; end
               end else m_pc++;
            end
            3: if (edge_seen) begin
               if (m_pc == SETTLE + SHIFT - 1) begin
                  if (!tone_det_n && rx_data) begin
                     m_car = 0;
                     if (m_ch == 1) begin m_done = 1; m_res = 1; m_phase = 4; end
                     else begin m_ch--; m_fhi = 1; m_phase = 1; m_wc = 0; end
                  end else begin m_car = 0; m_fhi = 0; m_done = 1; m_res = 2; m_phase = 4; end
               end else m_pc++;
            end
            default: m_phase = 0;
         endcase
      end
   end

   // compare on every clock, then move the reference and the analog loop model
   always @(negedge clk) begin
      if (!finished) begin
         chk(ch_sel == m_ch[1:0], "R2 ch_sel", ch_sel, m_ch);
         chk(freq_hi == m_fhi[0], "R3 freq_hi", freq_hi, m_fhi);
         chk(carrier_en == m_car[0], "R4 carrier_en", carrier_en, m_car);
         chk(done == m_done[0], "R7 done", done, m_done);
         chk(result == m_res[1:0], "R8 result", result, m_res);
      end
      if (ref_div == REF_HALF - 1) begin ref_div = 0; ref_clk_in = ~ref_clk_in; end
      else ref_div++;
      tone_det_n = carrier_en && (det_bad_ch == int'(ch_sel));
      rx_data    = carrier_en && !freq_hi && (rx_bad_ch != int'(ch_sel));
   end

   task automatic run_to_done();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      while (!done) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  %0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      chk(ch_sel == 0 && !carrier_en && !freq_hi && !done && result == 0, "R1 reset outputs",
          {ch_sel, carrier_en, freq_hi, done, result}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // all paths good: R2 order, R5/R6 checks, R7 good code
      run_to_done();
      chk(result == 2'b01, "R7 good code", result, 1);
      chk(ch_sel == 1, "R7 ends on path 1", ch_sel, 1);

      // path 2 busy for a while, below watchdog
      ch_busy = 3'b010;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      while (ch_sel != 2) @(negedge clk);
      repeat (15) @(negedge clk);
      chk(!carrier_en, "R4 waits for idle path", carrier_en, 0);
      ch_busy = 3'b000;
      while (!done) @(negedge clk);
      @(negedge clk);
      chk(result == 2'b01, "R4 busy then idle passes", result, 1);

      // detector stuck on path 3: first check fails
      det_bad_ch = 3;
      run_to_done();
      det_bad_ch = 0;
      chk(result == 2'b10, "R5 first check fault", result, 2);
      chk(ch_sel == 3, "R8 failing path 3 reported", ch_sel, 3);
      chk(!carrier_en, "R8 carrier off after fault", carrier_en, 0);

      // receive data stuck low on path 2: second check fails
      rx_bad_ch = 2;
      run_to_done();
      rx_bad_ch = 0;
      chk(result == 2'b10, "R6 second check fault", result, 2);
      chk(ch_sel == 2, "R8 path 1 skipped", ch_sel, 2);

      // path 1 never idle: watchdog
      ch_busy = 3'b001;
      run_to_done();
      chk(result == 2'b10, "R9 watchdog fault", result, 2);
      chk(ch_sel == 1, "R9 watchdog path", ch_sel, 1);
      ch_busy = 3'b000;

      // start during a run is ignored
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      while (ch_sel != 2) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      repeat (2) @(negedge clk);
      chk(ch_sel == 2, "R10 start ignored mid-run", ch_sel, 2);
      while (!done) @(negedge clk);
      @(negedge clk);
      chk(result == 2'b01, "R10 run completes", result, 1);

      // restart from done clears result
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk(!done && result == 0 && ch_sel == 3, "R10 restart clears", {done, result}, 0);
      while (!done) @(negedge clk);
      @(negedge clk);
      chk(result == 2'b01, "R10 restart result", result, 1);

      finish_run();
   end
endmodule